// File: doc/BRIEF.md
# Asynchronous Serial Controller with FIFOs

This block is a full-duplex UART. The transmitter and the receiver share one frame format and one baud rate. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. A host reaches the block through a small word-wide register port. Writing the data register queues a character for transmission. Reading the data register takes the oldest received character.

One control bit sets how much storage sits in each direction. In double-buffer mode each direction holds one character next to its shift register. In FIFO mode each direction holds a queue of `DEPTH` entries. `DEPTH` is 16 and must be a power of two.

With 9-bit frames the ninth bit can mark an address frame (1) or a data frame (0). While the wake filter is on, the receiver drops data frames. The receiver flags parity errors, framing errors and overruns in sticky status bits, which the host clears by writing ones. A loop-back bit routes the transmit stream into the receiver and holds the TX pin high. A 16-bit reload counter makes the oversampling tick, at 16 ticks per bit.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Register map by `reg_addr`: 0 is data, 1 is control, 2 is baud reload, 3 is status. Control bits: [0] 9-bit frames, [1] parity enable, [2] odd parity, [3] two stop bits, [4] FIFO mode, [5] address-wake filter, [6] loop-back. Status bits: [0] TX storage empty, [1] TX storage full, [2] RX data available, [3] transmitter idle, [4] parity error, [5] framing error, [6] overrun. A data read returns the character in bits [8:0]. After reset, control and baud read 0, status reads 0x009 and `txd` is high.
- R2: A frame is a start bit (0), then 8 or 9 data bits LSB first, then the parity bit if enabled, then 1 or 2 stop bits (1). With 8-bit frames, bit 8 of a written character is not sent and a received character reads 0 in bit 8. TX and RX always use the same control settings.
- R3: The parity bit makes the count of ones over data plus parity even, or odd when control bit 2 is set. The receiver sets status bit 4 when the received parity does not match. The character is still stored.
- R4: The receiver sets status bit 5 when any stop-bit sample is low. The character is still stored.
- R5: In double-buffer mode (control bit 4 = 0) each direction stores one character beyond its shift register. In FIFO mode each direction stores `DEPTH` characters. A data write while TX storage is full is ignored.
- R6: The receiver arms on a falling edge of the line. It confirms the start bit at the 8th tick, about mid-bit, and samples every later bit 16 ticks apart. A low pulse shorter than half a bit is ignored.
- R7: With 9-bit frames and the wake filter on, a frame whose ninth bit is 0 is discarded and sets no flag. A frame whose ninth bit is 1 is stored.
- R8: A frame that completes while RX storage is full is dropped and sets status bit 6. The stored characters stay unchanged.
- R9: Status bits 4 to 6 stay set until a status write with a 1 in that bit position. A write with 0 in that position leaves the bit set.
- R10: In loop-back the receiver takes the internal transmit stream, and `txd` stays high.
- R11: The baud tick fires once every reload+1 clocks, so one bit lasts 16*(reload+1) clocks.
- R12: Status bit 3 is set only when no character is being shifted out and the TX storage is empty. Status bits 0 and 1 follow the TX storage fill level against the current capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops RX storage on a data read |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
Loop-back runs a sweep over all sixteen combinations of length, parity, parity sense and stop count. A receiver that read parity or stop positions at the wrong offset would flag false errors or return corrupted characters. The transmit line is then decoded from outside at a slow baud setting. A wrong tick period would make the mid-bit samples drift into the wrong bits.

Hand-built frames hit the corner cases one at a time:
- a wrong parity bit and a low second stop bit, each of which must set its own flag;
- a short glitch, which a receiver that skipped the mid-bit confirm would take as a frame;
- a data frame under the wake filter, which must leave nothing behind;
- one frame too many for both buffer modes, where overwriting the stored data or dropping the wrong character shows up on read-back.

Sticky flags are checked against both a zero write and a one write.

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
  parameter int DEPTH  = 16,
  parameter int BAUD_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rxd,
  output logic        txd
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int FW = 13;

  logic [6:0]        ctrl;
  logic [BAUD_W-1:0] baud, bcnt;

  wire len9    = ctrl[0];
  wire par_en  = ctrl[1];
  wire par_odd = ctrl[2];
  wire stop2   = ctrl[3];
  wire fifo_en = ctrl[4];
  wire wake    = ctrl[5];
  wire loop_en = ctrl[6];

  wire [3:0]    nd    = len9 ? 4'd9 : 4'd8;
  wire [3:0]    nbits = 4'd2 + nd + {3'b0, par_en} + {3'b0, stop2};
  wire [3:0]    sp    = nd + 4'd1 + {3'b0, par_en};
  wire [CW-1:0] cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  wire [8:0]    dmask = {len9, 8'hFF};

  wire wr_dat  = reg_wr && reg_addr == 2'd0;
  wire wr_ctl  = reg_wr && reg_addr == 2'd1;
  wire wr_baud = reg_wr && reg_addr == 2'd2;
  wire wr_stat = reg_wr && reg_addr == 2'd3;
  wire rd_dat  = reg_rd && reg_addr == 2'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      baud <= '0;
    end else begin
      if (wr_ctl)  ctrl <= reg_wdata[6:0];
      if (wr_baud) baud <= reg_wdata[BAUD_W-1:0];
    end

  wire tick = (bcnt == '0);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? baud : bcnt - 1'b1;

  // transmit storage and shifter
  logic [8:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_busy;
  logic [FW-1:0] tx_sh, tx_frame;
  logic [3:0]    tx_left, tx_tc;

  wire tx_pop  = !tx_busy && tx_cnt != '0;
  wire tx_push = wr_dat && (tx_cnt < cap || tx_pop);
  wire [8:0] tx_hd = tx_mem[tx_rp] & dmask;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[8:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nd)) tx_frame[i+1] = tx_hd[i];
    if (par_en) tx_frame[nd + 4'd1] = par_odd ^ (^tx_hd);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      tx_tc   <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_sh   <= tx_frame;
      tx_left <= nbits;
      tx_tc   <= '0;
    end else if (tx_busy && tick) begin
      tx_tc <= tx_tc + 1'b1;
      if (tx_tc == 4'd15) begin
        tx_sh   <= {1'b1, tx_sh[FW-1:1]};
        tx_left <= tx_left - 1'b1;
        if (tx_left == 4'd1) tx_busy <= 1'b0;
      end
    end

  wire tx_line = !tx_busy || tx_sh[0];
  assign txd = loop_en || tx_line;

  // receiver
  logic [2:0]    rsync;
  logic          rx_on;
  logic [3:0]    rx_tc, rx_idx;
  logic [FW-1:0] rx_vec, rx_full;
  logic [8:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          perr, ferr, ovr;

  wire rx_in = loop_en ? tx_line : rxd;
  wire rcur  = rsync[1];
  wire rfall = rsync[2] && !rcur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync <= '1;
    else        rsync <= {rsync[1:0], rx_in};

  always_comb begin
    rx_full         = rx_vec;
    rx_full[rx_idx] = rcur;
  end

  wire       samp     = rx_on && tick && rx_tc == 4'd7;
  wire       rx_done  = samp && rx_idx == nbits - 4'd1;
  wire [8:0] rx_dat   = rx_full[9:1] & dmask;
  wire       perr_now = par_en && ((^rx_dat ^ rx_full[nd + 4'd1]) != par_odd);
  wire       ferr_now = !rx_full[sp] || (stop2 && !rx_full[sp + 4'd1]);
  wire       skip     = wake && len9 && !rx_dat[8];
  wire       rx_pop   = rd_dat && rx_cnt != '0;
  wire       rx_room  = rx_cnt < cap || rx_pop;
  wire       rx_push  = rx_done && !skip && rx_room;
  wire       ovr_now  = rx_done && !skip && !rx_room;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_on  <= 1'b0;
      rx_tc  <= '0;
      rx_idx <= '0;
      rx_vec <= '1;
    end else if (!rx_on) begin
      if (rfall) begin
        rx_on  <= 1'b1;
        rx_tc  <= '0;
        rx_idx <= '0;
      end
    end else if (tick) begin
      rx_tc <= rx_tc + 1'b1;
      if (rx_tc == 4'd7) begin
        if ((rx_idx == 4'd0 && rcur) || rx_done) rx_on <= 1'b0;
        rx_vec[rx_idx] <= rcur;
        rx_idx <= rx_idx + 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_dat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      perr <= 1'b0;
      ferr <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (rx_push && perr_now)            perr <= 1'b1;
      else if (wr_stat && reg_wdata[4])   perr <= 1'b0;
      if (rx_push && ferr_now)            ferr <= 1'b1;
      else if (wr_stat && reg_wdata[5])   ferr <= 1'b0;
      if (ovr_now)                        ovr  <= 1'b1;
      else if (wr_stat && reg_wdata[6])   ovr  <= 1'b0;
    end

  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt >= cap;
  wire tx_idle  = tx_empty && !tx_busy;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {7'b0, rx_mem[rx_rp]};
      2'd1:    reg_rdata = {9'b0, ctrl};
      2'd2:    reg_rdata = 16'(baud);
      default: reg_rdata = {9'b0, ovr, ferr, perr, tx_idle, rx_cnt != '0, tx_full, tx_empty};
    endcase

  p_dbuf_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fifo_en) && !fifo_en && $past(tx_cnt) <= 1) |-> tx_cnt <= 1);
  p_dbuf_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!fifo_en) && !fifo_en && $past(rx_cnt) <= 1) |-> rx_cnt <= 1);
  p_ovr_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovr) && !$past(rx_pop)) |-> rx_cnt == $past(rx_cnt));
  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(perr) && !($past(wr_stat) && $past(reg_wdata[4]))) |-> perr);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovr) && !($past(wr_stat) && $past(reg_wdata[6]))) |-> ovr);
  p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(baud) != '0) |-> !tick);
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !$past(tick) && !$past(tx_pop)) |-> $stable(tx_sh));
endmodule

// File: tb/uart_fifo_ctrl_test.sv
module uart_fifo_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, rxd = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        txd;

  uart_fifo_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd));

  int checks = 0, fails = 0;
  bit loop_mon = 0, done = 0;
  int loop_viol = 0, falls = 0;
  logic prev_txd = 1'b1;

  always @(negedge clk) begin
    if (loop_mon && txd !== 1'b1) loop_viol <= loop_viol + 1;
    prev_txd <= txd;
    if (prev_txd && !txd) falls <= falls + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'(a);
    #1 v = int'(reg_rdata);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic int cw(bit l9, bit p, bit od, bit s2, bit fe, bit wk, bit lp);
    return (int'(lp) << 6) | (int'(wk) << 5) | (int'(fe) << 4) | (int'(s2) << 3) |
           (int'(od) << 2) | (int'(p) << 1) | int'(l9);
  endfunction

  function automatic int nb(bit l9, bit p, bit s2);
    return 2 + (l9 ? 9 : 8) + int'(p) + int'(s2);
  endfunction

  function automatic logic [12:0] frm(int d, bit l9, bit p, bit od, bit s2, bit bp, bit bs);
    int n = l9 ? 9 : 8;
    int ones = 0;
    logic [12:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[i+1] = ((d >> i) & 1) != 0;
      ones += (d >> i) & 1;
    end
    if (p) f[n+1] = ((ones % 2) != 0) ^ od ^ bp;
    if (bs) f[n + 1 + int'(p) + int'(s2)] = 1'b0;
    return f;
  endfunction

  task automatic send(input logic [12:0] f, input int n, input int bitclk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (bitclk - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic decode(input logic [12:0] f, input int n, input int bitclk, input string req);
    int bad = 0;
    logic [12:0] got = '1;
    while (txd) @(negedge clk);
    repeat (bitclk / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (txd !== f[i]) bad++;
      repeat (bitclk) @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, f);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    int vals[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(3, v); chk("R1 reset status", v, 'h009);
    rd(1, v); chk("R1 reset control", v, 0);
    rd(2, v); chk("R1 reset baud", v, 0);
    chk("R1 reset txd", int'(txd), 1);

    // R2 R3 R4 R10 loop-back sweep over every frame format
    loop_mon = 1;
    for (int c = 0; c < 16; c++) begin
      bit l9 = c[0], p = c[1], od = c[2], s2 = c[3];
      vals[0] = 'h000; vals[1] = 'h1FF; vals[2] = 'h0A5 ^ c; vals[3] = 'h15A + c * 7;
      wr(1, cw(l9, p, od, s2, 1, 0, 1));
      for (int k = 0; k < 4; k++) wr(0, vals[k]);
      repeat (1000) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        rd(0, v);
        chk($sformatf("R2 loopback cfg%0d char%0d", c, k), v, l9 ? (vals[k] & 'h1FF) : (vals[k] & 'hFF));
      end
      rd(3, v);
      chk($sformatf("R3 R4 no error flags cfg%0d", c), v & 'h70, 0);
    end
    loop_mon = 0;
    chk("R10 txd high in loopback", loop_viol, 0);

    // R11 R2 R3 transmit line decode at slow baud
    wr(1, cw(1, 1, 1, 1, 1, 0, 0));
    wr(2, 2);
    wr(0, 'h1A3);
    decode(frm('h1A3, 1, 1, 1, 1, 0, 0), nb(1, 1, 1), 48, "R11 R2 R3 9O2 frame on txd");
    repeat (100) @(negedge clk);
    wr(1, cw(0, 1, 0, 0, 1, 0, 0));
    wr(0, 'h15C);
    decode(frm('h5C, 0, 1, 0, 0, 0, 0), nb(0, 1, 0), 48, "R11 R2 8E1 frame on txd");
    repeat (100) @(negedge clk);
    wr(2, 0);

    // R2 plain receive
    wr(1, cw(0, 0, 0, 0, 1, 0, 0));
    send(frm('h3C, 0, 0, 0, 0, 0, 0), nb(0, 0, 0), 16);
    rd(3, v); chk("R12 rx available", v & 'h74, 'h04);
    rd(0, v); chk("R2 received 8N1", v, 'h3C);

    // R3 parity error
    wr(1, cw(0, 1, 0, 0, 1, 0, 0));
    send(frm('h81, 0, 1, 0, 0, 1, 0), nb(0, 1, 0), 16);
    rd(3, v); chk("R3 parity flag", v & 'h70, 'h10);
    rd(0, v); chk("R3 data still stored", v, 'h81);
    wr(3, 0);
    rd(3, v); chk("R9 zero write keeps flag", v & 'h70, 'h10);
    wr(3, 'h10);
    rd(3, v); chk("R9 one write clears flag", v & 'h70, 0);

    // R4 framing error on second stop
    wr(1, cw(0, 0, 0, 1, 1, 0, 0));
    send(frm('h6E, 0, 0, 0, 1, 0, 1), nb(0, 0, 1), 16);
    rd(3, v); chk("R4 framing flag", v & 'h70, 'h20);
    rd(0, v); chk("R4 data still stored", v, 'h6E);
    wr(3, 'h70);

    // R6 glitch rejection
    wr(1, cw(0, 0, 0, 0, 1, 0, 0));
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd(3, v); chk("R6 glitch ignored", v & 'h74, 0);

    // R7 address wake filter
    wr(1, cw(1, 0, 0, 0, 1, 1, 0));
    send(frm('h055, 1, 0, 0, 0, 0, 0), nb(1, 0, 0), 16);
    rd(3, v); chk("R7 data frame discarded", v & 'h74, 0);
    send(frm('h1AA, 1, 0, 0, 0, 0, 0), nb(1, 0, 0), 16);
    rd(0, v); chk("R7 address frame stored", v, 'h1AA);

    // R8 R5 overrun in double-buffer mode
    wr(1, cw(0, 0, 0, 0, 0, 0, 0));
    send(frm('h11, 0, 0, 0, 0, 0, 0), nb(0, 0, 0), 16);
    send(frm('h22, 0, 0, 0, 0, 0, 0), nb(0, 0, 0), 16);
    rd(3, v); chk("R8 overrun flag double buffer", v & 'h74, 'h44);
    rd(0, v); chk("R8 first char kept", v, 'h11);
    rd(3, v); chk("R5 single entry drained", v & 'h04, 0);
    wr(3, 'h40);

    // R8 R5 overrun in FIFO mode
    wr(1, cw(0, 0, 0, 0, 1, 0, 0));
    for (int k = 0; k < 17; k++) send(frm('h30 + k, 0, 0, 0, 0, 0, 0), nb(0, 0, 0), 16);
    rd(3, v); chk("R8 overrun flag fifo", v & 'h44, 'h44);
    for (int k = 0; k < 16; k++) begin
      rd(0, v); chk($sformatf("R5 fifo order %0d", k), v, 'h30 + k);
    end
    rd(3, v); chk("R5 fifo drained", v & 'h04, 0);
    wr(3, 'h40);

    // R12 R5 transmit status in FIFO mode
    for (int k = 0; k < 17; k++) wr(0, 'hFF);
    rd(3, v); chk("R12 tx full fifo", v & 'h0B, 'h02);
    repeat (3000) @(negedge clk);
    rd(3, v); chk("R12 tx idle after drain", v & 'h0B, 'h09);

    // R5 double-buffer transmit drops the third write
    wr(1, cw(0, 0, 0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    falls = 0;
    wr(0, 'hFF); wr(0, 'hFF); wr(0, 'hFF);
    rd(3, v); chk("R12 tx full double buffer", v & 'h0B, 'h02);
    repeat (600) @(negedge clk);
    chk("R5 double buffer sends two frames", falls, 2);
    rd(3, v); chk("R12 idle after double buffer", v & 'h0B, 'h09);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule